// File: doc/BRIEF.md
# USB 2.0 Host Controller Status Register

This block keeps the 32-bit status word of a USB 2.0 host controller. It also handles the handshake between the run/stop command and the halted indication. Software reads the word through `reg_rdata` and clears event flags by writing ones through `reg_wr`/`reg_wdata`. The execution engine drives single-cycle event pulses and level indications into the block:

- a schedule advance;
- a failed memory read;
- a halted flag;
- the real on/off state of each schedule;
- a reclamation flag.

The block answers with a one-cycle forced clear of the run/stop command bit, a pending-doorbell flag for the command register, and a registered interrupt request gated by a six-bit enable mask.

The enable mask covers the six event flags in bits 5:0. Bit 5 records an async-advance interrupt, but only after the doorbell has armed it. Bit 4 records a host system error. Bits 3:0 collect four further engine event sources. Bits 15, 14 and 13 report what the engine really does, not what software asked for.

Top module: `usb_hc_status`

## Requirements
- R1: After reset `reg_rdata` is 0x00001000, with only bit 12 (halted) set. `doorbell_pend`, `run_clear` and `irq` are 0.
- R2: Bits 31:16 and 11:6 of `reg_rdata` always read 0, and writes to those positions have no effect.
- R3: Bits 5:0 are write-one-to-clear. A write with a 1 in position i clears bit i on the next edge, and a 0 in position i leaves bit i unchanged.
- R4: When a hardware set and a software clear reach the same event bit in the same cycle, the bit is 1 after that edge.
- R5: Bit 12 (halted) behaves as follows on each edge:
  - it becomes 0 on the edge after any cycle with `run_cmd`=1;
  - it becomes 1 on the edge after a cycle with `run_cmd`=0 and `eng_halted`=1;
  - otherwise it holds its value.
- R6: Bits 15 (async schedule on), 14 (periodic schedule on) and 13 (reclamation) equal `eng_async_on`, `eng_periodic_on` and `eng_reclaim` as sampled at the previous edge. Software writes do not change them.
- R7: When `sched_advance` is 1 while `doorbell_pend` is 1, bit 5 is set on that edge and `doorbell_pend` clears on the same edge, unless `doorbell_set` is also 1 in that cycle.
- R8: An advance with `doorbell_pend`=0 does not set bit 5. A `doorbell_set` pulse makes `doorbell_pend` 1 on the next edge, and it stays 1 until an advance occurs, whatever the run or halted state.
- R9: A `mem_rd_fail` pulse sets bit 4 on the next edge and makes `run_clear` 1 for exactly the cycle after that edge.
- R10: `irq` on each edge takes the OR over i in 0..5 of (status bit i AND `irq_en[i]`), using the values held before that edge.
- R11: Bits 3:0 are set on the edge after a 1 on the matching `aux_evt` line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Software write strobe for the status word |
| reg_wdata | input | 32 | Write data; ones clear event bits |
| run_cmd | input | 1 | Run/stop bit of the command register |
| doorbell_set | input | 1 | Software wrote 1 to the async-advance doorbell |
| eng_halted | input | 1 | Engine reports that execution has stopped |
| eng_async_on | input | 1 | Engine's real async schedule state |
| eng_periodic_on | input | 1 | Engine's real periodic schedule state |
| eng_reclaim | input | 1 | Engine reclamation flag |
| sched_advance | input | 1 | Pulse: async schedule advanced |
| mem_rd_fail | input | 1 | Pulse: a memory read returned non-success |
| aux_evt | input | 4 | Pulses for event bits 3:0 |
| irq_en | input | 6 | Interrupt enable per event bit 5:0 |
| reg_rdata | output | 32 | Status word read value |
| doorbell_pend | output | 1 | Doorbell armed and not yet consumed |
| run_clear | output | 1 | One-cycle pulse forcing run/stop to 0 |
| irq | output | 1 | Registered interrupt request |

## Verification
Every status bit and `doorbell_pend` responds one edge after its input. `run_clear` pulses one edge after a failed read. `irq` comes one edge later again, since it is derived from the flags already held in the register. The bench drives inputs on the falling edge and advances its reference state on the rising edge from the same inputs. It compares all outputs on the next falling edge, so each result is checked in exactly the cycle it is due. Directed steps cover reset, reserved-bit writes, write-one-to-clear, set/clear collisions and doorbell gating. These run alongside seeded random traffic.

// File: rtl/usb_hc_status_pkg.sv
package usb_hc_status_pkg;
   localparam int STS_W      = 32;
   localparam int EVT_W      = 6;
   localparam int POS_ADV    = 5;
   localparam int POS_SYSERR = 4;
   localparam int POS_HALT   = 12;
   localparam int POS_RECL   = 13;
   localparam int POS_PER    = 14;
   localparam int POS_ASYNC  = 15;
   localparam logic [STS_W-1:0] STS_RESET = 32'h0000_1000;
endpackage

// File: rtl/usb_hc_evt_bank.sv
module usb_hc_evt_bank #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flag_q
);
   generate
      if (N < 1) begin : g_bad_n
         $error("usb_hc_evt_bank: N must be at least 1");
      end
      for (genvar i = 0; i < N; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        flag_q[i] <= 1'b0;
            else if (set_i[i]) flag_q[i] <= 1'b1;
            else if (clr_i[i]) flag_q[i] <= 1'b0;
         end

         // R3
         w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !flag_q[i]);
         // R4
         set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flag_q[i]);
      end
   endgenerate
endmodule

// File: rtl/usb_hc_doorbell.sv
module usb_hc_doorbell (
   input  logic clk,
   input  logic rst_n,
   input  logic doorbell_set,
   input  logic sched_advance,
   output logic adv_hit,
   output logic pend_q
);
   assign adv_hit = sched_advance & pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            pend_q <= 1'b0;
      else if (doorbell_set) pend_q <= 1'b1;
      else if (sched_advance) pend_q <= 1'b0;
   end

   // R8
   pend_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !sched_advance) |=> pend_q);
   // R7
   pend_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && sched_advance && !doorbell_set) |=> !pend_q);
endmodule

// File: rtl/usb_hc_run_halt.sv
module usb_hc_run_halt #(
   parameter bit REG_MIRROR = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run_cmd,
   input  logic       eng_halted,
   input  logic       mem_rd_fail,
   input  logic [2:0] eng_state,
   output logic       halted_q,
   output logic       run_clear_q,
   output logic [2:0] mirror
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halted_q    <= 1'b1;
         run_clear_q <= 1'b0;
      end else begin
         run_clear_q <= mem_rd_fail;
         if (run_cmd)         halted_q <= 1'b0;
         else if (eng_halted) halted_q <= 1'b1;
      end
   end

   generate
      if (REG_MIRROR) begin : g_reg
         logic [2:0] mirror_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mirror_q <= '0;
            else        mirror_q <= eng_state;
         end
         assign mirror = mirror_q;
      end else begin : g_comb
         assign mirror = eng_state;
      end
   endgenerate

   // R5
   halt_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_cmd |=> !halted_q);
   // R5
   halt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_cmd && eng_halted) |=> halted_q);
   // R9
   run_clear_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_fail |=> run_clear_q);
endmodule

// File: rtl/usb_hc_status.sv
module usb_hc_status
   import usb_hc_status_pkg::*;
#(
   parameter int AUX_EVT    = 4,
   parameter bit REG_MIRROR = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr,
   input  logic [STS_W-1:0]     reg_wdata,
   input  logic                 run_cmd,
   input  logic                 doorbell_set,
   input  logic                 eng_halted,
   input  logic                 eng_async_on,
   input  logic                 eng_periodic_on,
   input  logic                 eng_reclaim,
   input  logic                 sched_advance,
   input  logic                 mem_rd_fail,
   input  logic [AUX_EVT-1:0]   aux_evt,
   input  logic [EVT_W-1:0]     irq_en,
   output logic [STS_W-1:0]     reg_rdata,
   output logic                 doorbell_pend,
   output logic                 run_clear,
   output logic                 irq
);
   localparam int NEVT = AUX_EVT + 2;

   generate
      if (NEVT != EVT_W) begin : g_bad_aux
         $error("usb_hc_status: AUX_EVT must leave bits 5:4 for advance and error");
      end
   endgenerate

   logic            adv_hit;
   logic            halted_q;
   logic [2:0]      mirror;
   logic [NEVT-1:0] evt_set, evt_clr, evt_q;
   logic            irq_q;

   usb_hc_doorbell u_bell (
      .clk           (clk),
      .rst_n         (rst_n),
      .doorbell_set  (doorbell_set),
      .sched_advance (sched_advance),
      .adv_hit       (adv_hit),
      .pend_q        (doorbell_pend)
   );

   usb_hc_run_halt #(.REG_MIRROR(REG_MIRROR)) u_run (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_cmd     (run_cmd),
      .eng_halted  (eng_halted),
      .mem_rd_fail (mem_rd_fail),
      .eng_state   ({eng_async_on, eng_periodic_on, eng_reclaim}),
      .halted_q    (halted_q),
      .run_clear_q (run_clear),
      .mirror      (mirror)
   );

   assign evt_set = {adv_hit, mem_rd_fail, aux_evt};
   assign evt_clr = reg_wr ? reg_wdata[NEVT-1:0] : '0;

   usb_hc_evt_bank #(.N(NEVT)) u_evt (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (evt_set),
      .clr_i  (evt_clr),
      .flag_q (evt_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(evt_q & irq_en);
   end
   assign irq = irq_q;

   always_comb begin
      reg_rdata                     = '0;
      reg_rdata[NEVT-1:0]           = evt_q;
      reg_rdata[POS_HALT]           = halted_q;
      reg_rdata[POS_ASYNC:POS_RECL] = mirror;
   end

   // R2
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[31:16] == '0) && (reg_rdata[11:6] == '0));
   // R8
   adv_needs_bell_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sched_advance && !doorbell_pend && !reg_rdata[POS_ADV]) |=> !reg_rdata[POS_ADV]);
   // R9
   syserr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_fail |=> reg_rdata[POS_SYSERR]);
   // R10
   irq_syserr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[POS_SYSERR] && irq_en[POS_SYSERR]) |=> irq);
endmodule

// File: tb/usb_hc_status_tb.sv
module usb_hc_status_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 0;
   logic [31:0] reg_wdata = '0;
   logic        run_cmd = 0, doorbell_set = 0, eng_halted = 0;
   logic        eng_async_on = 0, eng_periodic_on = 0, eng_reclaim = 0;
   logic        sched_advance = 0, mem_rd_fail = 0;
   logic [3:0]  aux_evt = '0;
   logic [5:0]  irq_en = '0;
   logic [31:0] reg_rdata;
   logic        doorbell_pend, run_clear, irq;

   int checks = 0, fails = 0;
   bit done = 0;

   // reference state
   logic [5:0] m_evt;
   logic       m_pend, m_halt, m_rclr, m_irq;
   logic [2:0] m_mir;

   always #(CLK_PERIOD/2) clk = ~clk;

   usb_hc_status u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .run_cmd(run_cmd), .doorbell_set(doorbell_set), .eng_halted(eng_halted),
      .eng_async_on(eng_async_on), .eng_periodic_on(eng_periodic_on),
      .eng_reclaim(eng_reclaim), .sched_advance(sched_advance),
      .mem_rd_fail(mem_rd_fail), .aux_evt(aux_evt), .irq_en(irq_en),
      .reg_rdata(reg_rdata), .doorbell_pend(doorbell_pend),
      .run_clear(run_clear), .irq(irq)
   );

   function automatic logic [31:0] exp_word();
      logic [31:0] w = '0;
      w[5:0]   = m_evt;
      w[12]    = m_halt;
      w[15:13] = m_mir;
      return w;
   endfunction

   function automatic logic [5:0] next_evt();
      logic [5:0] s, c;
      s = {sched_advance & m_pend, mem_rd_fail, aux_evt};
      c = reg_wr ? reg_wdata[5:0] : 6'h0;
      return s | (m_evt & ~c);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_evt <= '0; m_pend <= 0; m_halt <= 1; m_rclr <= 0; m_irq <= 0; m_mir <= '0;
      end else begin
         m_evt  <= next_evt();
         m_pend <= doorbell_set | (m_pend & ~sched_advance);
         m_halt <= run_cmd ? 1'b0 : (eng_halted ? 1'b1 : m_halt);
         m_rclr <= mem_rd_fail;
         m_irq  <= |(m_evt & irq_en);
         m_mir  <= {eng_async_on, eng_periodic_on, eng_reclaim};
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic compare_all();
      logic [31:0] e = exp_word();
      chk("R2 reserved", {16'h0, reg_rdata[31:16]} | {26'h0, reg_rdata[11:6]}, 32'h0);
      chk("R5 halted", {31'h0, reg_rdata[12]}, {31'h0, e[12]});
      chk("R6 mirror", {29'h0, reg_rdata[15:13]}, {29'h0, e[15:13]});
      chk("R7 advance bit", {31'h0, reg_rdata[5]}, {31'h0, e[5]});
      chk("R9 syserr bit", {31'h0, reg_rdata[4]}, {31'h0, e[4]});
      chk("R11 aux bits", {28'h0, reg_rdata[3:0]}, {28'h0, e[3:0]});
      chk("R8 doorbell pend", {31'h0, doorbell_pend}, {31'h0, m_pend});
      chk("R9 run_clear", {31'h0, run_clear}, {31'h0, m_rclr});
      chk("R10 irq", {31'h0, irq}, {31'h0, m_irq});
   endtask

   task automatic quiet();
      reg_wr = 0; reg_wdata = '0; doorbell_set = 0; sched_advance = 0;
      mem_rd_fail = 0; aux_evt = '0;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      compare_all();
   endtask

   initial begin
      void'($urandom(32'd1977));
      #(CLK_PERIOD*3);
      @(negedge clk);
      // R1 reset state
      chk("R1 reset word", reg_rdata, 32'h0000_1000);
      chk("R1 reset outputs", {29'h0, doorbell_pend, run_clear, irq}, 32'h0);
      rst_n = 1;
      step();

      // R2: write ones everywhere including reserved bits
      quiet(); reg_wr = 1; reg_wdata = 32'hFFFF_FFFF; step();
      quiet(); step();
      chk("R2 after write", reg_rdata & 32'hFFFF_0FC0, 32'h0);

      // R11 + R3: set aux bits, clear some, keep others
      aux_evt = 4'hF; step(); quiet();
      reg_wr = 1; reg_wdata = 32'h0000_0005; step(); quiet(); step();
      chk("R3 partial clear", {28'h0, reg_rdata[3:0]}, 32'h0000_000A);

      // R4: set and clear collide on bit 1
      aux_evt = 4'h2; reg_wr = 1; reg_wdata = 32'h0000_000F; step(); quiet();
      chk("R4 set wins", {28'h0, reg_rdata[3:0]}, 32'h0000_0002);

      // R8: advance without doorbell
      sched_advance = 1; step(); quiet();
      chk("R8 no doorbell", {31'h0, reg_rdata[5]}, 32'h0);
      // R8: doorbell held while halted, R7 consumed by advance
      doorbell_set = 1; step(); quiet(); step(); step();
      chk("R8 pend held", {31'h0, doorbell_pend}, 32'h1);
      sched_advance = 1; step(); quiet();
      chk("R7 advance sets", {31'h0, reg_rdata[5], doorbell_pend}, 32'h2);

      // R9 + R5 + R10
      run_cmd = 1; irq_en = 6'h10; step();
      chk("R5 running", {31'h0, reg_rdata[12]}, 32'h0);
      mem_rd_fail = 1; step(); quiet();
      chk("R9 error", {30'h0, reg_rdata[4], run_clear}, 32'h3);
      step();
      chk("R10 irq raised", {31'h0, irq}, 32'h1);
      run_cmd = 0; eng_halted = 1; step();
      chk("R5 stopped", {31'h0, reg_rdata[12]}, 32'h1);

      // random phase
      for (int n = 0; n < 4000; n++) begin
         reg_wr          = ($urandom % 4) == 0;
         reg_wdata       = $urandom;
         doorbell_set    = ($urandom % 10) == 0;
         sched_advance   = ($urandom % 6) == 0;
         mem_rd_fail     = ($urandom % 20) == 0;
         aux_evt         = {($urandom%10)==0, ($urandom%10)==0, ($urandom%10)==0, ($urandom%10)==0};
         if (($urandom % 25) == 0) run_cmd = ~run_cmd;
         eng_halted      = ($urandom % 3) == 0;
         eng_async_on    = ($urandom % 2) == 0;
         eng_periodic_on = ($urandom % 2) == 0;
         eng_reclaim     = ($urandom % 4) == 0;
         if ((n % 50) == 0) irq_en = $urandom;
         step();
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD*100000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule